// File: doc/BRIEF.md
# Vectored Interrupt Controller with Atomic Enable Aliases

This block gathers up to 32 peripheral interrupt lines into a single request line for a processor. Every line is resynchronised to the controller clock and then classified by a sense kind chosen per line at elaboration time: rising edge, falling edge, active-high level or active-low level. A qualifying event latches a status bit. The status bits are masked by a per-line enable. The lowest-numbered surviving line is reported through a vector register.

Software reaches the controller through a simple 32-bit register port addressed by byte offset. Enables can be rewritten wholesale. They can also be changed bit by bit through separate set-only and clear-only aliases, so no read-modify-write sequence is needed. Latched status is cleared by writing a mask to the acknowledge word. A two-bit gate field must be fully on before the request line can rise.

Top module: `vic_top`

## Requirements
- R1: After reset the enable, status and gate fields are zero, `irq_o` is low, and the vector word reads 0xFFFFFFFF.
- R2: Each input's sense kind is given by the 2-bit field `SENSE[2i+1:2i]`: 0 rising edge, 1 falling edge, 2 high level, 3 low level. An edge-kind input latches its status bit once per qualifying edge and never on a held level.
- R3: A level-kind input sets its status bit in every cycle its synchronised level is active. An acknowledge of that bit while the level is still active leaves it set.
- R4: An input change first appears in the status word on the third rising clock edge after it is applied: two synchroniser stages, then the status latch.
- R5: The pending word (byte offset 4) reads status AND enable. The status word is at offset 0.
- R6: A write to offset 16 sets the enable bits that are 1 in the data and leaves every other enable bit unchanged.
- R7: A write to offset 20 clears the enable bits that are 1 in the data and leaves every other enable bit unchanged.
- R8: A write to offset 8 replaces the whole enable word, and the enable word reads back at that offset.
- R9: A write to offset 12 clears the status bits that are 1 in the data. An edge-kind bit stays clear until a new edge arrives.
- R10: The gate field is data bits [1:0] at offset 28 and reads back there. `irq_o` is high exactly when some pending bit is set and both gate bits are 1.
- R11: The vector word (offset 24) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when none is pending.
- R12: Writes to offsets 0, 4 and 24 change nothing. An access with nonzero address bits [1:0] is ignored and reads zero. Reads of offsets 12, 16 and 20 return zero, and unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC (32) | Raw peripheral interrupt lines, asynchronous |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address during a read strobe, else zero |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A change on an input line reaches the status word on the third rising edge after it is driven. Register writes take effect on the edge that samples them. Reads, the pending word, the vector and `irq_o` are combinational from the registered state, so they are valid in the same cycle. The bench keeps a cycle-stepped model that advances once per rising edge from the inputs driven in the preceding half cycle. It compares every register word and the request line just after each falling edge. Directed checks confirm the exact three-edge latency by sampling after the second and after the third edge.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        SNS_RISE = 2'd0,
        SNS_FALL = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    // word index = byte offset / 4
    typedef enum logic [2:0] {
        RG_STATUS = 3'd0,
        RG_PEND   = 3'd1,
        RG_ENAB   = 3'd2,
        RG_ACK    = 3'd3,
        RG_ENSET  = 3'd4,
        RG_ENCLR  = 3'd5,
        RG_VEC    = 3'd6,
        RG_GATE   = 3'd7
    } reg_e;

    localparam logic [1:0] GATE_ON = 2'b11;

endpackage

// File: rtl/vic_detect.sv
module vic_detect
    import vic_pkg::*;
#(
    parameter int                   N_SRC = 32,
    parameter logic [2*N_SRC-1:0]   SENSE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] evt_o
);

    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic [N_SRC-1:0] s3;
    } pipe_t;

    pipe_t            p_d, p_q;
    logic [N_SRC-1:0] idle;
    logic [N_SRC-1:0] edge_kind;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            localparam sense_e KIND = sense_e'(SENSE[2*i +: 2]);
            // falling and low-active lines rest high; reset the stages there
            assign idle[i]      = (KIND == SNS_FALL) || (KIND == SNS_LOW);
            assign edge_kind[i] = (KIND == SNS_RISE) || (KIND == SNS_FALL);
            assign evt_o[i] = (KIND == SNS_RISE) ? ( p_q.s2[i] & ~p_q.s3[i]) :
                              (KIND == SNS_FALL) ? (~p_q.s2[i] &  p_q.s3[i]) :
                              (KIND == SNS_HIGH) ?   p_q.s2[i] :
                                                    ~p_q.s2[i];
        end
    endgenerate

    always_comb begin
        p_d    = p_q;
        p_d.s1 = src_i;
        p_d.s2 = p_q.s1;
        p_d.s3 = p_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= {idle, idle, idle};
        else        p_q <= p_d;
    end

    // an edge-kind line never reports events in two consecutive cycles (R2)
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_o) & evt_o & edge_kind) == '0);

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_SRC = 32,
    localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o
);

    // scan from the top so the lowest set index is the last one written
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int                 N_SRC = 32,
    parameter logic [2*N_SRC-1:0] SENSE = 64'hE4E4_E4E4_E4E4_E4E4,
    parameter int                 DW    = 32,
    parameter int                 AW    = 5,
    localparam int                IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_o
);

    typedef struct packed {
        logic [N_SRC-1:0] enab;
        logic [N_SRC-1:0] stat;
        logic [1:0]       gate;
    } regs_t;

    regs_t            r_d, r_q;
    logic [N_SRC-1:0] evt;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] ack_mask;
    logic [N_SRC-1:0] wmask;
    logic             aligned;
    logic             wr;
    reg_e             widx;
    logic             hit;
    logic [IW-1:0]    idx;
    logic [DW-1:0]    rd;

    vic_detect #(.N_SRC(N_SRC), .SENSE(SENSE)) i_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .evt_o (evt)
    );

    assign pend = r_q.stat & r_q.enab;

    vic_prio #(.N_SRC(N_SRC)) i_prio (
        .pend_i (pend),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = reg_e'(bus_addr[4:2]);
    assign wr      = bus_en && bus_we && aligned;
    assign wmask   = bus_wdata[N_SRC-1:0];

    always_comb begin
        r_d      = r_q;
        ack_mask = '0;
        if (wr) begin
            case (widx)
                RG_ENAB:  r_d.enab = wmask;
                RG_ENSET: r_d.enab = r_q.enab | wmask;
                RG_ENCLR: r_d.enab = r_q.enab & ~wmask;
                RG_ACK:   ack_mask = wmask;
                RG_GATE:  r_d.gate = bus_wdata[1:0];
                default:  ;
            endcase
        end
        // a fresh event outranks an acknowledge in the same cycle
        r_d.stat = (r_q.stat & ~ack_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd = '0;
        case (widx)
            RG_STATUS: rd[N_SRC-1:0] = r_q.stat;
            RG_PEND:   rd[N_SRC-1:0] = pend;
            RG_ENAB:   rd[N_SRC-1:0] = r_q.enab;
            RG_VEC:    rd = hit ? DW'(idx) : '1;
            RG_GATE:   rd[1:0] = r_q.gate;
            default:   rd = '0;
        endcase
    end

    assign bus_rdata = (bus_en && !bus_we && aligned) ? rd : '0;
    assign irq_o     = hit && (r_q.gate == GATE_ON);

    assert_enset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_ENSET) |=>
            ((r_q.enab & $past(wmask)) == $past(wmask)) &&
            ((r_q.enab & ~$past(wmask)) == ($past(r_q.enab) & ~$past(wmask))));

    assert_enclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_ENCLR) |=>
            ((r_q.enab & $past(wmask)) == '0) &&
            ((r_q.enab & ~$past(wmask)) == ($past(r_q.enab) & ~$past(wmask))));

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && widx == RG_ACK) |=> ((r_q.stat & $past(wmask) & ~$past(evt)) == '0));

    assert_stat_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.stat & ~$past(r_q.stat) & ~$past(evt)) == '0);

    assert_gate_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.gate != GATE_ON) |-> !irq_o);

    assert_vec_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pend[idx] && ((pend & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0)));

    assert_vec_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pend == '0));

endmodule

// File: tb/test_vic_top.sv
`timescale 1ns/10ps
module test_vic_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [N-1:0] m_s1, m_s2, m_s3, m_stat, m_en;
    logic [1:0]   m_gate;

    always #2 clk = ~clk;

    vic_top i_vic_top (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // R2 encoding: line i has kind i%4 (0 rise, 1 fall, 2 high, 3 low)
    function automatic int kind_of(int i);
        return i % 4;
    endfunction

    function automatic logic [N-1:0] idle_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (kind_of(i) == 1) || (kind_of(i) == 3);
        return v;
    endfunction

    function automatic logic [31:0] low_index(logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] model_read(int w);
        case (w)
            0: return m_stat;
            1: return m_stat & m_en;
            2: return m_en;
            6: return low_index(m_stat & m_en);
            7: return {30'd0, m_gate};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one rising edge; the model consumes what was driven before it
    task automatic tick();
        logic [N-1:0] ev;
        logic [N-1:0] ackm;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            case (kind_of(i))
                0: ev[i] =  m_s2[i] & ~m_s3[i];
                1: ev[i] = ~m_s2[i] &  m_s3[i];
                2: ev[i] =  m_s2[i];
                default: ev[i] = ~m_s2[i];
            endcase
        end
        ackm = '0;
        if (bus_en && bus_we && bus_addr[1:0] == 2'b00) begin
            case (bus_addr[4:2])
                3'd2: m_en = bus_wdata;
                3'd3: ackm = bus_wdata;
                3'd4: m_en = m_en | bus_wdata;
                3'd5: m_en = m_en & ~bus_wdata;
                3'd7: m_gate = bus_wdata[1:0];
                default: ;
            endcase
        end
        m_stat = (m_stat & ~ackm) | ev;
        m_s3 = m_s2;
        m_s2 = m_s1;
        m_s1 = src;
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(int w, logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = 5'(w * 4); bus_wdata = d;
        tick();
        bus_en = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(int w, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = 5'(w * 4);
        #0.1;
        d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        for (int w = 0; w < 8; w++) begin
            rd(w, d);
            chk($sformatf("%s word%0d", tag, w), d, model_read(w));
        end
        chk($sformatf("%s irq R10", tag), 32'(irq_o),
            32'(((m_stat & m_en) != '0) && m_gate == 2'b11));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        src = idle_vec();
        repeat (3) @(posedge clk);
        m_s1 = idle_vec(); m_s2 = idle_vec(); m_s3 = idle_vec();
        m_stat = '0; m_en = '0; m_gate = '0;
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(6, d); chk("R1 vector after reset", d, 32'hFFFF_FFFF);
        rd(0, d); chk("R1 status after reset", d, 32'h0);
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        check_all("R1");

        // R8 direct enable write, R10 gate on
        wr(2, 32'hFFFF_FFFF);
        wr(7, 32'h3);
        check_all("R8");

        // R4 latency on rising line 0
        src[0] = 1'b1;
        ticks(2);
        rd(0, d); chk("R4 status not yet after two edges", d & 32'h1, 32'h0);
        tick();
        rd(0, d); chk("R4 status set on third edge", d & 32'h1, 32'h1);
        chk("R10 irq with gate on", 32'(irq_o), 32'h1);
        rd(6, d); chk("R11 vector line 0", d, 32'h0);

        // R2/R9 edge held high does not refire after acknowledge
        wr(3, 32'h1);
        ticks(4);
        rd(0, d); chk("R9 edge stays clear", d & 32'h1, 32'h0);
        chk("R11 no pending vector", model_read(6), 32'hFFFF_FFFF);
        rd(6, d); chk("R11 vector none", d, 32'hFFFF_FFFF);

        // R2 falling line 1
        src[1] = 1'b0;
        ticks(3);
        rd(0, d); chk("R2 falling latched", d & 32'h2, 32'h2);
        rd(6, d); chk("R11 vector line 1", d, 32'h1);

        // R3 high level line 2 survives acknowledge while active
        src[2] = 1'b1;
        ticks(3);
        wr(3, 32'h4);
        rd(0, d); chk("R3 level reasserts after ack", d & 32'h4, 32'h4);
        src[2] = 1'b0;
        ticks(3);
        wr(3, 32'h4);
        rd(0, d); chk("R3 level clears once inactive", d & 32'h4, 32'h0);
        check_all("R3");

        // R7/R6 atomic enable aliases move the vector
        wr(5, 32'h2);
        rd(6, d); chk("R7 clear moves vector", d, 32'hFFFF_FFFF);
        rd(2, d); chk("R7 other enables kept", d, 32'hFFFF_FFFD);
        wr(4, 32'h2);
        rd(6, d); chk("R6 set restores vector", d, 32'h1);
        rd(1, d); chk("R5 pending word", d, 32'h2);

        // R10 partial gate values
        wr(7, 32'h1);
        chk("R10 gate 01 blocks irq", 32'(irq_o), 32'h0);
        wr(7, 32'hFFFF_FFFE);
        chk("R10 gate 10 blocks irq", 32'(irq_o), 32'h0);
        rd(7, d); chk("R10 gate readback", d, 32'h2);
        wr(7, 32'h3);

        // R12 read-only words and misaligned access
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);
        check_all("R12 read-only");
        bus_en = 1; bus_we = 1; bus_addr = 5'd9; bus_wdata = 32'h0;
        tick();
        bus_en = 0; bus_we = 0;
        rd(2, d); chk("R12 misaligned write ignored", d, m_en);
        bus_en = 1; bus_addr = 5'd10; #0.1;
        chk("R12 misaligned read zero", bus_rdata, 32'h0);
        bus_en = 0;

        // random phase
        for (int it = 0; it < 800; it++) begin
            int op;
            op = $urandom % 8;
            if (op < 3) begin
                src = src ^ ($urandom & $urandom & $urandom);
                tick();
            end else if (op < 7) begin
                int w;
                logic [31:0] dat;
                w = $urandom % 8;
                dat = $urandom;
                if (w == 7 && ($urandom % 2)) dat = 32'h3;
                if (w == 3 && ($urandom % 2)) dat = 32'hFFFF_FFFF;
                wr(w, dat);
            end else begin
                tick();
            end
            check_all($sformatf("R5 random it%0d", it));
        end

        finish_run();
    end

endmodule